// File: doc/BRIEF.md
# Two-Wire Serial Byte Receiver with Wait and Interrupt Timing

This block receives bytes from a two-wire clocked serial bus, with open-drain clock and data lines. It shifts in each byte MSB first and counts rising clock edges. It sends or detects the acknowledge in the ninth slot and compares each received byte with a stored slave address. It also flags the start condition (here called the command condition) and the stop condition (here called the bus-release condition).

The block sets where the interrupt request falls and whether the clock is then stretched. The interrupt can come on the eighth or the ninth rising clock edge. After it, the block either lets the clock run or holds the clock line low until the host releases it. The host reaches every setting and flag through a four-entry register port.

Both bus lines are modelled as a drive-low enable plus a sampled input level. The outside world forms the wired-AND of the two.

Top module: `sbus_wait_ctrl`

## Requirements
- R1: After reset, all four registers read 0. The clock drive-low enable is 1 (because clock-line bit CTL[4] is 0), data drive-low is 0, and the interrupt and busy outputs are 0.
- R2: Register map: index 0 is CTL, 1 is the slave address, 2 is STATUS and 3 is the receive buffer. CTL[4]=0 drives the clock line low and CTL[4]=1 releases it. STATUS[0] always returns the sampled clock line level.
- R3: With wait mode CTL[1:0] set to 0 or 1, the interrupt is a one-cycle pulse. It comes on the 8th rising clock edge after a start condition, and no wait follows (STATUS[5] stays 0).
- R4: With wait mode 2, the interrupt comes on the 8th rising edge. STATUS[5] then sets, and once the clock is low the block holds the clock drive-low enable asserted whatever CTL[4] says.
- R5: With wait mode 3, there is no interrupt on the 8th edge. The interrupt comes on the 9th rising edge, and the same wait and clock hold as in R4 follow.
- R6: Writing CTL with bit 5 set clears the wait and the clock hold. The clock line then follows CTL[4] again, and the next rising edge is counted.
- R7: Data is sampled on each rising clock edge, MSB first. The completed byte is copied into the receive buffer on the 8th rising edge.
- R8: STATUS[4] is updated on each 8th edge. It is 1 when the received byte equals the slave address over all bits (CTL[3]=0), or over bits 7..1 only (CTL[3]=1).
- R9: With CTL[6]=1, data drive-low turns on at the falling edge after the 8th rising edge. Writing CTL with bit 7 set turns it on at once. In both cases it turns off at the falling edge after the 9th rising edge.
- R10: On each 9th rising edge, STATUS[1] takes the value 1 if the data line is low and 0 if it is high.
- R11: Data falling while the clock is high sets STATUS[2]. Data rising while the clock is high sets STATUS[3]. Either condition resets the edge count to 0. Writing 1 to STATUS bits 1, 2 or 3 clears that flag.
- R12: With CTL[2]=1, a bus-release condition also pulses the interrupt. With CTL[2]=0, it does not.
- R13: The busy output is STATUS[7] (a host-writable enable) ANDed with the active wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index for writes |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Register index for reads |
| rd_data | output | DATA_W | Read data (combinational) |
| scl_i | input | 1 | Sampled clock line level |
| sda_i | input | 1 | Sampled data line level |
| scl_low_o | output | 1 | Clock line drive-low enable |
| sda_low_o | output | 1 | Data line drive-low enable |
| irq_o | output | 1 | One-cycle interrupt pulse |
| busy_o | output | 1 | Gated busy indication |

## Verification
Each wait mode is driven with the same framed byte. This shows whether the interrupt falls on the 8th or the 9th edge, and whether the clock is then stretched until release. A restart after three bits shows that a start condition clears a half-finished count.

Random bytes are sent against random slave addresses, some differing only in bit 0, with the mask bit chosen at random. These bytes check MSB-first capture and both compare widths.

Ninth slots are sent with the data line high, with it low, and with the automatic or immediate acknowledge enabled. These separate acknowledge detection from acknowledge generation.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam logic [1:0] REG_CTL  = 2'd0;
    localparam logic [1:0] REG_SADR = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_RXB  = 2'd3;

    // control register bit positions
    localparam int CB_SRC   = 2;
    localparam int CB_MASK  = 3;
    localparam int CB_SCLR  = 4;
    localparam int CB_WREL  = 5;
    localparam int CB_AUTO  = 6;
    localparam int CB_NOW   = 7;

    // status register bit positions
    localparam int SB_SCL   = 0;
    localparam int SB_ACK   = 1;
    localparam int SB_CMD   = 2;
    localparam int SB_REL   = 3;
    localparam int SB_MATCH = 4;
    localparam int SB_WAIT  = 5;
    localparam int SB_BUSY  = 7;

    typedef enum logic [1:0] {
        WM_EOT8A = 2'd0,
        WM_EOT8B = 2'd1,
        WM_HOLD8 = 2'd2,
        WM_HOLD9 = 2'd3
    } wmode_e;

endpackage

// File: rtl/sbus_cond_detect.sv
module sbus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic rel_evt
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_i;
        prev_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_i & ~prev_q.scl;
    assign scl_fall  = ~scl_i & prev_q.scl;
    assign start_evt = scl_i & prev_q.scl & prev_q.sda & ~sda_i;
    assign rel_evt   = scl_i & prev_q.scl & ~prev_q.sda & sda_i;

endmodule

// File: rtl/sbus_addr_match.sv
module sbus_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx,
    input  logic [W-1:0] ref_addr,
    input  logic         ign_lsb,
    output logic         hit
);
    logic [W-1:0] bit_ok;

    for (genvar g = 0; g < W; g++) begin : g_bit
        if (g == 0) begin : g_lsb
            assign bit_ok[g] = ign_lsb | (rx[g] == ref_addr[g]);
        end else begin : g_upper
            assign bit_ok[g] = (rx[g] == ref_addr[g]);
        end
    end

    assign hit = &bit_ok;

    // a full-width hit must mean identical bytes
    always_comb begin
        if (!ign_lsb && hit) begin
            assert_full_compare_R8: assert (rx == ref_addr);
        end
    end

endmodule

// File: rtl/sbus_wait_ctrl.sv
module sbus_wait_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output logic              irq_o,
    output logic              busy_o
);
    import sbus_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        wmode_e            mode;
        logic              src_sel;
        logic              mask_lsb;
        logic              scl_rel;
        logic              ack_auto;
        logic              busy_en;
        logic [DATA_W-1:0] saddr;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rxbuf;
        logic [CNT_W-1:0]  cnt;
        logic              wait_pend;
        logic              hold;
        logic              ack_drv;
        logic              ack_det;
        logic              cmd_det;
        logic              rel_det;
        logic              match;
        logic              irq;
    } st_t;

    st_t st_d, st_q;

    logic scl_rise, scl_fall, start_evt, rel_evt;
    logic [CNT_W-1:0]  cnt_nx;
    logic [DATA_W-1:0] shifted;
    logic              cmp_hit;
    logic              rel_wr;

    sbus_cond_detect u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .rel_evt  (rel_evt)
    );

    assign shifted = {st_q.shreg[DATA_W-2:0], sda_i};
    assign cnt_nx  = (st_q.cnt == ACK_SLOT) ? CNT_ONE : st_q.cnt + CNT_ONE;
    assign rel_wr  = wr_en && (wr_addr == REG_CTL) && wr_data[CB_WREL];

    sbus_addr_match #(.W(DATA_W)) u_cmp (
        .rx      (shifted),
        .ref_addr(st_q.saddr),
        .ign_lsb (st_q.mask_lsb),
        .hit     (cmp_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;

        // host writes
        if (wr_en) begin
            case (wr_addr)
                REG_CTL: begin
                    st_d.mode     = wmode_e'(wr_data[1:0]);
                    st_d.src_sel  = wr_data[CB_SRC];
                    st_d.mask_lsb = wr_data[CB_MASK];
                    st_d.scl_rel  = wr_data[CB_SCLR];
                    st_d.ack_auto = wr_data[CB_AUTO];
                    if (wr_data[CB_WREL]) begin
                        st_d.wait_pend = 1'b0;
                        st_d.hold      = 1'b0;
                    end
                    if (wr_data[CB_NOW]) st_d.ack_drv = 1'b1;
                end
                REG_SADR: st_d.saddr = wr_data;
                REG_STAT: begin
                    if (wr_data[SB_ACK]) st_d.ack_det = 1'b0;
                    if (wr_data[SB_CMD]) st_d.cmd_det = 1'b0;
                    if (wr_data[SB_REL]) st_d.rel_det = 1'b0;
                    st_d.busy_en = wr_data[SB_BUSY];
                end
                default: ;
            endcase
        end

        // bus conditions
        if (start_evt) begin
            st_d.cnt     = '0;
            st_d.cmd_det = 1'b1;
            st_d.ack_drv = 1'b0;
        end
        if (rel_evt) begin
            st_d.cnt     = '0;
            st_d.rel_det = 1'b1;
            st_d.ack_drv = 1'b0;
            if (st_q.src_sel) st_d.irq = 1'b1;
        end

        // rising clock edge: count, shift, latch, acknowledge sample
        if (scl_rise) begin
            st_d.cnt = cnt_nx;
            if (cnt_nx <= LAST_BIT) st_d.shreg = shifted;
            if (cnt_nx == LAST_BIT) begin
                st_d.rxbuf = shifted;
                st_d.match = cmp_hit;
            end
            if (cnt_nx == ACK_SLOT) st_d.ack_det = ~sda_i;
            if (cnt_nx == ((st_q.mode == WM_HOLD9) ? ACK_SLOT : LAST_BIT)) begin
                st_d.irq = 1'b1;
                if (st_q.mode[1]) st_d.wait_pend = 1'b1;
            end
        end

        // falling clock edge: acknowledge drive window
        if (scl_fall) begin
            if (st_q.cnt == ACK_SLOT) st_d.ack_drv = 1'b0;
            else if (st_q.cnt == LAST_BIT && st_q.ack_auto) st_d.ack_drv = 1'b1;
        end

        // clock stretch starts once the line is low
        if (st_q.wait_pend && st_d.wait_pend && !scl_i) st_d.hold = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scl_low_o = st_q.hold | ~st_q.scl_rel;
    assign sda_low_o = st_q.ack_drv;
    assign irq_o     = st_q.irq;
    assign busy_o    = st_q.busy_en & st_q.wait_pend;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CTL: begin
                rd_data[1:0]    = st_q.mode;
                rd_data[CB_SRC]  = st_q.src_sel;
                rd_data[CB_MASK] = st_q.mask_lsb;
                rd_data[CB_SCLR] = st_q.scl_rel;
                rd_data[CB_AUTO] = st_q.ack_auto;
            end
            REG_SADR: rd_data = st_q.saddr;
            REG_STAT: begin
                rd_data[SB_SCL]   = scl_i;
                rd_data[SB_ACK]   = st_q.ack_det;
                rd_data[SB_CMD]   = st_q.cmd_det;
                rd_data[SB_REL]   = st_q.rel_det;
                rd_data[SB_MATCH] = st_q.match;
                rd_data[SB_WAIT]  = st_q.wait_pend;
                rd_data[SB_BUSY]  = st_q.busy_en;
            end
            default: rd_data = st_q.rxbuf;
        endcase
    end

    // ---------------- assertions ----------------
    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= ACK_SLOT);

    assert_cond_clears_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || rel_evt) |=> (st_q.cnt == '0));

    assert_irq_on_eighth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && st_q.cnt == LAST_BIT - CNT_ONE && !st_q.mode[1]) |=> irq_o);

    assert_wait_on_eighth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && st_q.cnt == LAST_BIT - CNT_ONE && st_q.mode == WM_HOLD8)
        |=> (irq_o && st_q.wait_pend));

    assert_quiet_eighth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && st_q.cnt == LAST_BIT - CNT_ONE && st_q.mode == WM_HOLD9) |=> !irq_o);

    assert_hold_until_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && !rel_wr) |=> scl_low_o);

endmodule

// File: tb/sbus_wait_ctrl_bench.sv
`timescale 1ns/1ps
module sbus_wait_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_i, sda_i;
    logic       scl_low_o, sda_low_o, irq_o, busy_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_i = scl_m & ~scl_low_o;
    assign sda_i = sda_m & ~sda_low_o;

    sbus_wait_ctrl #(.DATA_W(8)) u_sbus_wait_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .scl_i(scl_i), .sda_i(sda_i),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
        .irq_o(irq_o), .busy_o(busy_o)
    );

    function automatic logic [7:0] ctl(logic [1:0] md, logic src, logic msk, logic aut);
        return {1'b0, aut, 1'b0, 1'b1, msk, src, md};
    endfunction

    function automatic logic exp_match(logic [7:0] rx, logic [7:0] sa, logic msk);
        return msk ? (rx[7:1] == sa[7:1]) : (rx == sa);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a; #0.1; v = rd_data;
    endtask

    task automatic send_bit(input logic b, output logic irq_seen);
        @(negedge clk); sda_m = b;
        @(negedge clk); scl_m = 1'b1;
        @(negedge clk); irq_seen = irq_o;
        @(negedge clk); scl_m = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] irqs);
        for (int i = 7; i >= 0; i--) begin
            logic s;
            send_bit(b[i], s);
            irqs[i] = s;
        end
    endtask

    task automatic bus_start();
        @(negedge clk); sda_m = 1'b1; scl_m = 1'b1;
        @(negedge clk);
        @(negedge clk); sda_m = 1'b0;
        @(negedge clk); scl_m = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_stop(output logic irq_seen);
        @(negedge clk); sda_m = 1'b0;
        @(negedge clk); scl_m = 1'b1;
        @(negedge clk); sda_m = 1'b1;
        @(negedge clk); irq_seen = irq_o;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, irqs, sa, dat;
        logic       s, msk;
        void'($urandom(32'd20240611));

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(2'd0, v); check("R1 ctl", v, 8'h00);
        rd(2'd1, v); check("R1 saddr", v, 8'h00);
        rd(2'd2, v); check("R1 status", v, 8'h00);
        rd(2'd3, v); check("R1 rxbuf", v, 8'h00);
        check("R1 scl_low", scl_low_o, 1'b1);
        check("R1 sda_low", sda_low_o, 1'b0);
        check("R1 irq", irq_o, 1'b0);
        check("R1 busy", busy_o, 1'b0);

        // R2 clock-line control and sense
        wr(2'd0, ctl(2'd0, 1'b0, 1'b0, 1'b0));
        check("R2 scl released", scl_low_o, 1'b0);
        rd(2'd2, v); check("R2 sense high", v[0], 1'b1);

        // R11 start flag, R3 mode 0 byte, R7 capture, R10 ack low
        bus_start();
        rd(2'd2, v); check("R11 cmd flag", v[2], 1'b1);
        send_byte(8'hA5, irqs);
        check("R3 irq on 8th only", irqs, 8'h01);
        rd(2'd3, v); check("R7 rx A5", v, 8'hA5);
        rd(2'd2, v); check("R3 no wait", v[5], 1'b0);
        send_bit(1'b0, s);
        check("R3 no irq on 9th", s, 1'b0);
        rd(2'd2, v); check("R10 ack seen", v[1], 1'b1);
        bus_stop(s);
        check("R12 no irq src0", s, 1'b0);
        rd(2'd2, v); check("R11 rel flag", v[3], 1'b1);
        wr(2'd2, 8'h0E);
        rd(2'd2, v); check("R11 flags cleared", v[3:1], 3'b000);

        // R10 ack high, mode 1
        wr(2'd0, ctl(2'd1, 1'b0, 1'b0, 1'b0));
        bus_start();
        send_byte(8'h5A, irqs);
        check("R3 mode1 irq", irqs, 8'h01);
        send_bit(1'b1, s);
        rd(2'd2, v); check("R10 no ack", v[1], 1'b0);
        bus_stop(s);

        // R11 restart mid-byte resets count
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b1, s);
        bus_start();
        send_byte(8'h3C, irqs);
        check("R11 count reset irq", irqs, 8'h01);
        rd(2'd3, v); check("R11 rx after restart", v, 8'h3C);
        send_bit(1'b1, s);

        // R12 release interrupt with src select 1
        wr(2'd0, ctl(2'd0, 1'b1, 1'b0, 1'b0));
        bus_stop(s);
        check("R12 irq on release", s, 1'b1);

        // R4 mode 2 with auto ack (R9) and busy (R13)
        wr(2'd2, 8'h8E);
        wr(2'd0, ctl(2'd2, 1'b0, 1'b0, 1'b1));
        bus_start();
        send_byte(8'hC3, irqs);
        check("R4 irq on 8th", irqs, 8'h01);
        check("R4 clock held", scl_low_o, 1'b1);
        check("R9 auto ack drive", sda_low_o, 1'b1);
        check("R13 busy on", busy_o, 1'b1);
        rd(2'd2, v); check("R4 wait flag", v[5], 1'b1);
        @(negedge clk); sda_m = 1'b1; scl_m = 1'b1;
        repeat (3) tick();
        check("R4 line low while held", scl_i, 1'b0);
        wr(2'd0, ctl(2'd2, 1'b0, 1'b0, 1'b1) | 8'h20);
        check("R6 clock released", scl_low_o, 1'b0);
        check("R13 busy off", busy_o, 1'b0);
        tick();
        rd(2'd2, v); check("R9 ack detected from own drive", v[1], 1'b1);
        @(negedge clk); scl_m = 1'b0;
        tick();
        check("R9 ack drive off", sda_low_o, 1'b0);
        bus_stop(s);
        wr(2'd2, 8'h0E);

        // R5 mode 3
        wr(2'd0, ctl(2'd3, 1'b0, 1'b0, 1'b0));
        bus_start();
        send_byte(8'h81, irqs);
        check("R5 no irq in byte", irqs, 8'h00);
        send_bit(1'b0, s);
        check("R5 irq on 9th", s, 1'b1);
        check("R5 clock held", scl_low_o, 1'b1);
        wr(2'd0, ctl(2'd3, 1'b0, 1'b0, 1'b0) | 8'h20);
        check("R6 release mode3", scl_low_o, 1'b0);
        bus_stop(s);

        // R9 immediate ack
        wr(2'd0, ctl(2'd0, 1'b0, 1'b0, 1'b0));
        bus_start();
        send_byte(8'h0F, irqs);
        wr(2'd0, ctl(2'd0, 1'b0, 1'b0, 1'b0) | 8'h80);
        check("R9 ack now", sda_low_o, 1'b1);
        send_bit(1'b1, s);
        rd(2'd2, v); check("R9 ack now seen", v[1], 1'b1);
        check("R9 ack now off", sda_low_o, 1'b0);
        bus_stop(s);

        // R8 directed mask corner
        wr(2'd1, 8'hA4);
        wr(2'd0, ctl(2'd0, 1'b0, 1'b1, 1'b0));
        bus_start(); send_byte(8'hA5, irqs); send_bit(1'b1, s); bus_stop(s);
        rd(2'd2, v); check("R8 masked lsb match", v[4], 1'b1);
        wr(2'd0, ctl(2'd0, 1'b0, 1'b0, 1'b0));
        bus_start(); send_byte(8'hA5, irqs); send_bit(1'b1, s); bus_stop(s);
        rd(2'd2, v); check("R8 full compare miss", v[4], 1'b0);

        // random bytes: R7 capture, R8 compare
        for (int n = 0; n < 20; n++) begin
            sa  = 8'($urandom);
            dat = (n % 3 == 0) ? (sa ^ 8'($urandom & 1)) : 8'($urandom);
            msk = 1'($urandom);
            wr(2'd1, sa);
            wr(2'd0, ctl(2'd0, 1'b0, msk, 1'b0));
            bus_start();
            send_byte(dat, irqs);
            check("R3 random irq", irqs, 8'h01);
            rd(2'd3, v); check("R7 random rx", v, dat);
            rd(2'd2, v); check("R8 random match", v[4], exp_match(dat, sa, msk));
            send_bit(1'b1, s);
            bus_stop(s);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule